// File: doc/BRIEF.md
# Latched-Address 8-to-1 Selector

This block picks one bit out of an eight-bit data word and presents it on two outputs: one carries the bit as it is and the other carries its inverse. Two holding stages sit in front of the selector. The address stage follows the select input while the lock control is low and keeps its last value while the lock control is high. The data stage follows the data word while the pass control is high and keeps the captured word while the pass control is low. Both outputs share one drive condition that combines three enables. When that condition is false, both outputs float. A separate flag output reports whether the outputs are being driven.

The design targets a clocked fabric. Each holding stage is a clock-enabled register that samples on every rising edge while its control allows it. The selected bit, its complement and the drive flag are all registered. A synchronous active-high reset clears the address, the data word and the output registers to zero.

Top module: `latched_sel8`

## Requirements
- R1: While `rst` is high at a clock edge, the held address and the held data word become 0 and `drive_en` becomes 0. After reset, if the enables allow driving and both holding stages are closed, the outputs show `y`=0 and `y_n`=1.
- R2: While `addr_lock` is low, the held address takes the value of `sel` at every clock edge.
- R3: While `addr_lock` is high, the held address keeps its value and changes on `sel` have no effect on `y`.
- R4: While `data_pass` is high, the held data word takes the value of `din` at every clock edge.
- R5: While `data_pass` is low, the held data word keeps the value captured at the last edge with `data_pass` high, and changes on `din` have no effect on `y`.
- R6: Both outputs are driven, and `drive_en` is 1, only when `oe_a_n`=0, `oe_b_n`=0 and `oe_c`=1. The other seven combinations float both outputs and give `drive_en`=0.
- R7: Whenever `drive_en` is 1, `y_n` is the inverse of `y`.
- R8: The held address is a binary number with `sel[2]` as the most significant bit. Address k drives `din[k]` onto `y`, so 000 selects `din[0]` and 111 selects `din[7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Data word to select from |
| sel | input | 3 | Binary select address |
| addr_lock | input | 1 | High holds the address, low lets it follow `sel` |
| data_pass | input | 1 | High lets the data word follow `din`, low holds it |
| oe_a_n | input | 1 | Output enable, active low |
| oe_b_n | input | 1 | Output enable, active low |
| oe_c | input | 1 | Output enable, active high |
| y | output | 1 | Selected bit, high impedance when not driven |
| y_n | output | 1 | Inverse of the selected bit, high impedance when not driven |
| drive_en | output | 1 | 1 when `y` and `y_n` are driven |

## Verification
A change on `sel` or `din` passes through a holding register and then the output register, so it reaches `y` and `y_n` at the second rising edge after it is applied. A change on the enables reaches `drive_en` at the first edge. The bench holds every stimulus steady for two edges and samples one nanosecond after the second edge. At that point every result is due, and the bench's model updates its state once per stimulus. The float state is checked through `drive_en`, so the checks do not depend on how high-impedance values resolve.

// File: rtl/latched_sel8_pkg.sv
package latched_sel8_pkg;

  typedef struct packed {
    logic a_n;
    logic b_n;
    logic c;
  } oe_ctrl_t;

  function automatic logic drive_ok(input oe_ctrl_t oe);
    return (!oe.a_n) && (!oe.b_n) && oe.c;
  endfunction

endpackage

// File: rtl/sel_hold.sv
module sel_hold #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] sel_in,
  output logic [W-1:0] sel_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (!hold) begin
      sel_q <= sel_in;
    end
  end

endmodule

// File: rtl/data_hold.sv
module data_hold #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pass,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] d_q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        d_q[i] <= 1'b0;
      end else if (pass) begin
        d_q[i] <= d_in[i];
      end
    end
  end

endmodule

// File: rtl/addr_decode.sv
module addr_decode #(
  parameter int W = 3,
  localparam int N = 1 << W
) (
  input  logic [W-1:0] addr,
  output logic [N-1:0] onehot
);

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign onehot[i] = (addr == W'(i));
  end

endmodule

// File: rtl/out_stage.sv
module out_stage
  import latched_sel8_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_q,
  input  logic [N-1:0] pick,
  input  oe_ctrl_t     oe,
  output logic         y_q,
  output logic         yn_q,
  output logic         drv_q
);

  logic bit_sel;
  assign bit_sel = |(d_q & pick);

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q   <= 1'b0;
      yn_q  <= 1'b1;
      drv_q <= 1'b0;
    end else begin
      y_q   <= bit_sel;
      yn_q  <= ~bit_sel;
      drv_q <= drive_ok(oe);
    end
  end

endmodule

// File: rtl/latched_sel8.sv
module latched_sel8
  import latched_sel8_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int N_IN = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  din,
  input  logic [SEL_W-1:0] sel,
  input  logic             addr_lock,
  input  logic             data_pass,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic             oe_c,
  output logic             y,
  output logic             y_n,
  output logic             drive_en
);

  logic [SEL_W-1:0] sel_q;
  logic [N_IN-1:0]  data_q;
  logic [N_IN-1:0]  pick;
  logic             y_q;
  logic             yn_q;
  logic             drv_q;
  oe_ctrl_t         oe;

  assign oe = '{a_n: oe_a_n, b_n: oe_b_n, c: oe_c};

  sel_hold #(.W(SEL_W)) u_sel (
    .clk(clk), .rst(rst), .hold(addr_lock), .sel_in(sel), .sel_q(sel_q)
  );

  data_hold #(.N(N_IN)) u_data (
    .clk(clk), .rst(rst), .pass(data_pass), .d_in(din), .d_q(data_q)
  );

  addr_decode #(.W(SEL_W)) u_dec (
    .addr(sel_q), .onehot(pick)
  );

  out_stage #(.N(N_IN)) u_out (
    .clk(clk), .rst(rst), .d_q(data_q), .pick(pick), .oe(oe),
    .y_q(y_q), .yn_q(yn_q), .drv_q(drv_q)
  );

  assign y        = drv_q ? y_q  : 1'bz;
  assign y_n      = drv_q ? yn_q : 1'bz;
  assign drive_en = drv_q;

endmodule

// File: rtl/latched_sel8_chk.sv
module latched_sel8_chk #(
  parameter int SEL_W = 3,
  localparam int N_IN = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst,
  input logic [N_IN-1:0]  din,
  input logic [SEL_W-1:0] sel,
  input logic             addr_lock,
  input logic             data_pass,
  input logic             oe_a_n,
  input logic             oe_b_n,
  input logic             oe_c,
  input logic             drive_en,
  input logic [SEL_W-1:0] sel_q,
  input logic [N_IN-1:0]  data_q,
  input logic             y_q,
  input logic             yn_q
);

  AST_SEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !addr_lock |=> sel_q == $past(sel));                       // R2

  AST_SEL_KEEP: assert property (@(posedge clk) disable iff (rst)
    addr_lock |=> $stable(sel_q));                             // R3

  AST_DATA_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    data_pass |=> data_q == $past(din));                       // R4

  AST_DATA_KEEP: assert property (@(posedge clk) disable iff (rst)
    !data_pass |=> $stable(data_q));                           // R5

  AST_DRIVE_RULE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> drive_en == ($past(oe_c) && !$past(oe_a_n) && !$past(oe_b_n))); // R6

  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> (yn_q == !y_q));                              // R7

endmodule

bind latched_sel8 latched_sel8_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .din(din), .sel(sel), .addr_lock(addr_lock),
  .data_pass(data_pass), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .oe_c(oe_c),
  .drive_en(drive_en), .sel_q(sel_q), .data_q(data_q), .y_q(y_q), .yn_q(yn_q)
);

// File: tb/latched_sel8_test.sv
`timescale 1ns/1ps
module latched_sel8_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] din;
  logic [2:0] sel;
  logic       addr_lock, data_pass, oe_a_n, oe_b_n, oe_c;
  wire        y, y_n;
  logic       drive_en;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [2:0] m_sel;
  logic [7:0] m_data;

  always #2 clk = ~clk;

  latched_sel8 uut (
    .clk(clk), .rst(rst), .din(din), .sel(sel), .addr_lock(addr_lock),
    .data_pass(data_pass), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .oe_c(oe_c),
    .y(y), .y_n(y_n), .drive_en(drive_en)
  );

  function automatic logic exp_drive(input logic a_n, input logic b_n, input logic c);
    return (a_n == 1'b0) && (b_n == 1'b0) && (c == 1'b1);
  endfunction

  function automatic logic exp_bit(input logic [7:0] d, input logic [2:0] a);
    return d[a];
  endfunction

  task automatic check(input string req, input logic act, input logic expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, expv);
    end
  endtask

  task automatic apply(input logic [7:0] d, input logic [2:0] s, input logic lk,
                       input logic ps, input logic a_n, input logic b_n, input logic c);
    din = d; sel = s; addr_lock = lk; data_pass = ps;
    oe_a_n = a_n; oe_b_n = b_n; oe_c = c;
    if (!lk) m_sel = s;
    if (ps) m_data = d;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic check_out(input string req);
    logic ed;
    ed = exp_drive(oe_a_n, oe_b_n, oe_c);
    check(req, drive_en, ed);
    if (ed) begin
      check(req, y, exp_bit(m_data, m_sel));
      check("R7", y_n, ~exp_bit(m_data, m_sel));
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    rst = 1'b1; din = 8'hFF; sel = 3'd5; addr_lock = 1'b1; data_pass = 1'b0;
    oe_a_n = 1'b0; oe_b_n = 1'b0; oe_c = 1'b1;
    m_sel = '0; m_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", drive_en, 1'b0);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1", drive_en, 1'b1);
    check("R1", y, 1'b0);
    check("R1", y_n, 1'b1);

    // R8 and R2: sweep every address with the address stage open
    for (int k = 0; k < 8; k++) begin
      apply(8'(1 << k), 3'(k), 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      check_out("R8");
      apply(~8'(1 << k), 3'(k), 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      check_out("R2");
    end

    // R3: address held while locked
    apply(8'b0000_0100, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    apply(8'b0000_0100, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    apply(8'b0000_0100, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R3", y, 1'b1);
    apply(8'b0000_0100, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R3", y, 1'b1);

    // R4 then R5: data captured, later changes ignored
    apply(8'b1010_0101, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    check_out("R4");
    apply(8'b0101_1010, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R5", y, 1'b1);
    apply(8'b0000_0000, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R5", y, 1'b1);

    // R6: all eight enable combinations
    for (int c = 0; c < 8; c++) begin
      apply(m_data, m_sel, 1'b1, 1'b0, c[2], c[1], c[0]);
      check_out("R6");
    end

    // Random mix of all controls
    for (int i = 0; i < 300; i++) begin
      logic [7:0] oe_r;
      oe_r = 8'($urandom);
      apply(8'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
            oe_r[0] & oe_r[3], oe_r[1] & oe_r[4], oe_r[2] | oe_r[5]);
      check_out("R6");
      if (drive_en) check_out("R8");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule